// File: doc/BRIEF.md
# Steerable Byte-Programmed Watchdog

This block supervises software with a one-shot countdown that is configured by a single control byte. The byte holds three things. The first is a coarse scale that multiplies the count by a power of four. The second is a five-bit multiplier. The third is a steering bit that picks what happens when the count runs out. The count advances only on a tick input, which a prescaler elsewhere on the chip pulses once every sixteenth of a second.

Software keeps the watchdog alive in one of two ways. It can rewrite the control byte, or it can read the flags register. Either action reloads the countdown and clears the timeout flag. When the countdown runs out, the flag is raised. If steering is set, the block then requests a system reset, clears its own control byte and clears bit 6 of a neighbouring control byte. If steering is clear, it pulses an interrupt instead.

The registers sit at these byte addresses: 0 is flags, 1 is the watchdog control byte, 2 is the neighbouring control byte and 3 reads as 0x00.

Top module: `steer_wdog`

## Requirements
- R1: In the control byte, bits 1:0 are the scale S, bits 6:2 are the multiplier M and bit 7 is steering. The timeout is M × 4^S ticks. Expiry happens at the clock edge that samples the (M × 4^S)-th tick after the most recent reload.
- R2: A multiplier of zero leaves the watchdog disarmed. After such a reload, no flag, interrupt or reset request appears, however many ticks arrive.
- R3: A write to address 1 stores the byte, which then reads back at address 1. The same write clears the timeout flag and restarts the countdown from the new value.
- R4: A read strobe at address 0 restarts the countdown from the stored control byte and clears the flag. Read data during the strobe cycle still shows the flag as it was before the strobe.
- R5: On expiry the flag becomes 1. Address 0 then reads 0x80, with bit 7 as the flag and every other bit 0.
- R6: On expiry with steering set, rst_req_o is high for exactly one cycle, starting the cycle after the expiry edge. Address 1 then reads 0x00, and address 2 has bit 6 cleared with its other bits kept. No interrupt is raised.
- R7: On expiry with steering clear, irq_o is high for exactly one cycle and the control byte is kept. The countdown is one-shot, so no further expiry occurs until the next reload.
- R8: Writes to address 0 leave the flag unchanged.
- R9: Only ticks advance the countdown. A reload in the same cycle as the final tick wins, and no expiry occurs.
- R10: After reset every register reads 0x00 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Clock enable, one pulse per 1/16 s |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Read strobe (services the watchdog at address 0) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The countdown is run with three scale/multiplier pairs (5, 12 and 128 ticks). The measured tick counts tell a wrong field split, or a wrong power of four, apart from a plain off-by-one. The watchdog is also serviced periodically, both by flag reads and by writes, to separate the two reload paths. A zero multiplier is left to run for hundreds of ticks to show the block stays disarmed. Reloads and flag reads are placed exactly on the final tick to show which one wins. Both steering settings are driven to expiry, and the register read-back after each one tells the reset path from the interrupt path.

// File: rtl/steer_wdog_pkg.sv
package steer_wdog_pkg;
  localparam int unsigned ADDR_W        = 2;
  localparam int unsigned FLAG_BIT      = 7;
  localparam int unsigned NEIGHBOUR_BIT = 6;

  typedef enum logic [ADDR_W-1:0] {
    REG_FLAGS = 2'd0,
    REG_WDOG  = 2'd1,
    REG_CTRL  = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/steer_wdog_interval.sv
module steer_wdog_interval #(
  parameter int unsigned RES_W  = 2,
  parameter int unsigned MULT_W = 5,
  parameter int unsigned CNT_W  = 11
) (
  input  logic [RES_W-1:0]  res_i,
  input  logic [MULT_W-1:0] mult_i,
  output logic [CNT_W-1:0]  ticks_o
);
  localparam int unsigned STEPS = 1 << RES_W;

  logic [CNT_W-1:0] scaled [STEPS];

  // One shifted copy of the multiplier per scale step (power of four).
  for (genvar g = 0; g < STEPS; g++) begin : g_scale
    assign scaled[g] = CNT_W'(mult_i) << (2 * g);
  end

  assign ticks_o = scaled[res_i];
endmodule

// File: rtl/steer_wdog_count.sv
module steer_wdog_count #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             live;

  // A zero count means disarmed; it is reached by loading zero or by expiring.
  assign live     = (cnt_q != '0);
  assign expire_o = tick_i & ~load_i & (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (tick_i && live) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/steer_wdog_regs.sv
module steer_wdog_regs
  import steer_wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_wdog_i,
  input  logic              wr_ctrl_i,
  input  logic              service_i,
  input  logic              expire_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] wdog_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              flag_o,
  output logic              rst_req_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] wdog_q, wdog_d;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic              flag_q, flag_d;
  logic              rst_q, rst_d;
  logic              irq_q, irq_d;
  logic              steer;

  assign steer = wdog_q[DATA_W-1];

  always_comb begin
    wdog_d = wdog_q;
    if (wr_wdog_i) begin
      wdog_d = wdata_i;
    end else if (expire_i && steer) begin
      wdog_d = '0;
    end

    ctrl_d = wr_ctrl_i ? wdata_i : ctrl_q;
    if (expire_i && steer) begin
      ctrl_d[NEIGHBOUR_BIT] = 1'b0;
    end

    flag_d = flag_q;
    if (wr_wdog_i || service_i) begin
      flag_d = 1'b0;
    end else if (expire_i) begin
      flag_d = 1'b1;
    end

    rst_d = expire_i & steer;
    irq_d = expire_i & ~steer;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdog_q <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      wdog_q <= wdog_d;
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      rst_q  <= rst_d;
      irq_q  <= irq_d;
    end
  end

  assign wdog_o    = wdog_q;
  assign ctrl_o    = ctrl_q;
  assign flag_o    = flag_q;
  assign rst_req_o = rst_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/steer_wdog.sv
module steer_wdog
  import steer_wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RES_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o,
  output logic              irq_o
);
  localparam int unsigned MULT_W = DATA_W - 1 - RES_W;
  localparam int unsigned CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_q = rst_sync_q[1];

  logic              wr_wdog, wr_ctrl, service, reload, expire;
  logic [DATA_W-1:0] wdog_q, ctrl_q, load_src;
  logic              flag_q;
  logic [CNT_W-1:0]  load_ticks;

  assign wr_wdog  = wr_en_i & (addr_i == REG_WDOG);
  assign wr_ctrl  = wr_en_i & (addr_i == REG_CTRL);
  assign service  = rd_en_i & (addr_i == REG_FLAGS);
  assign reload   = wr_wdog | service;
  assign load_src = wr_wdog ? wdata_i : wdog_q;

  steer_wdog_interval #(
    .RES_W (RES_W),
    .MULT_W(MULT_W),
    .CNT_W (CNT_W)
  ) u_interval (
    .res_i  (load_src[RES_W-1:0]),
    .mult_i (load_src[DATA_W-2:RES_W]),
    .ticks_o(load_ticks)
  );

  steer_wdog_count #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_q),
    .tick_i    (tick_i),
    .load_i    (reload),
    .load_val_i(load_ticks),
    .expire_o  (expire)
  );

  steer_wdog_regs #(
    .DATA_W(DATA_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_q),
    .wr_wdog_i(wr_wdog),
    .wr_ctrl_i(wr_ctrl),
    .service_i(service),
    .expire_i (expire),
    .wdata_i  (wdata_i),
    .wdog_o   (wdog_q),
    .ctrl_o   (ctrl_q),
    .flag_o   (flag_q),
    .rst_req_o(rst_req_o),
    .irq_o    (irq_o)
  );

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      REG_FLAGS: rdata_o = {flag_q, {(DATA_W-1){1'b0}}};
      REG_WDOG:  rdata_o = wdog_q;
      REG_CTRL:  rdata_o = ctrl_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/steer_wdog_chk.sv
module steer_wdog_chk
  import steer_wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdog_q,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              flag_q,
  input logic              rst_req_o,
  input logic              irq_o
);
  p_rst_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |=> !irq_o);

  p_one_path_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(rst_req_o && irq_o));

  p_rst_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    rst_req_o |-> (wdog_q == '0 && !ctrl_q[NEIGHBOUR_BIT]));

  p_flag_on_expiry_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rst_req_o || irq_o) |-> flag_q);

  p_write_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && addr_i == REG_WDOG) |=> !flag_q);

  p_service_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_en_i && addr_i == REG_FLAGS) |=> (!flag_q && !rst_req_o && !irq_o));

  p_flags_ro_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && addr_i == REG_FLAGS && !rd_en_i && !tick_i) |=> $stable(flag_q));

  p_tick_only_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !tick_i |=> !(rst_req_o || irq_o));
endmodule

bind steer_wdog steer_wdog_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_n_q),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .wdog_q   (wdog_q),
  .ctrl_q   (ctrl_q),
  .flag_q   (flag_q),
  .rst_req_o(rst_req_o),
  .irq_o    (irq_o)
);

// File: tb/sim_steer_wdog.sv
`timescale 1ns/1ps
module sim_steer_wdog;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic       tick_man = 1'b0, tick_auto_en = 1'b0, auto_pulse = 1'b0;
  wire        tick = tick_auto_en ? auto_pulse : tick_man;
  wire  [7:0] rdata;
  wire        rst_req, irq;

  always #2.5 clk = ~clk;

  steer_wdog u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(rst_req), .irq_o(irq)
  );

  int    checks = 0, fails = 0;
  bit    done = 0;
  string cur_req = "R10";

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Tick source: one pulse every three clocks.
  int div = 0;
  always @(negedge clk) begin
    div = (div == 2) ? 0 : div + 1;
    auto_pulse = (div == 0);
  end

  // Behavioural reference model.
  int m_wd = 0, m_ct = 0, m_fl = 0, m_cnt = 0, m_rs = 0, m_iq = 0, tsl = 0;
  int ld_w, svc, ex, st;

  function automatic int ticks_for(input int v);
    return ((v >> 2) & 31) * (1 << (2 * (v & 3)));
  endfunction

  function automatic int mread(input int a);
    case (a)
      0: return m_fl << 7;
      1: return m_wd;
      2: return m_ct;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wd = 0; m_ct = 0; m_fl = 0; m_cnt = 0; m_rs = 0; m_iq = 0; tsl = 0;
    end else begin
      ld_w = (wr_en && addr == 2'd1);
      svc  = (rd_en && addr == 2'd0);
      ex   = (tick && m_cnt == 1 && !ld_w && !svc);
      st   = (m_wd >> 7) & 1;
      m_rs = ex && st;
      m_iq = ex && !st;
      if (ld_w || svc) tsl = 0; else if (tick) tsl++;
      if (wr_en && addr == 2'd2) m_ct = wdata;
      if (ld_w) begin
        m_wd = wdata; m_fl = 0; m_cnt = ticks_for(wdata);
      end else if (svc) begin
        m_fl = 0; m_cnt = ticks_for(m_wd);
      end else if (ex) begin
        m_fl = 1; m_cnt = 0;
        if (st) begin m_wd = 0; m_ct = m_ct & 8'hBF; end
      end else if (tick && m_cnt != 0) begin
        m_cnt--;
      end
    end
    #1;
    if (rst_n) begin
      chk(cur_req, "rdata", rdata, mread(addr));
      chk(cur_req, "rst_req", rst_req, m_rs);
      chk(cur_req, "irq", irq, m_iq);
    end
  end

  int irq_cnt = 0, rst_cnt = 0;
  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (rst_req) rst_cnt++;
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic flags_rd(output int v);
    @(negedge clk); rd_en = 1; addr = 2'd0; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic peek(input logic [1:0] a, output int v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic wait_fire(input int maxc, output int gi, output int gr, output int nt);
    gi = 0; gr = 0; nt = -1;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (irq || rst_req) begin gi = irq; gr = rst_req; nt = tsl; break; end
    end
  endtask

  task automatic man_tick();
    @(negedge clk); tick_man = 1;
    @(negedge clk); tick_man = 0;
  endtask

  task automatic run_timeout(input string req, input logic [7:0] v, input int exp_ticks);
    int gi, gr, nt;
    cur_req = req;
    bus_wr(2'd1, v);
    wait_fire(exp_ticks * 3 + 30, gi, gr, nt);
    chk(req, "irq fired", gi, 1);
    chk(req, "rst_req fired", gr, 0);
    chk(req, "ticks to expiry", nt, exp_ticks);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    int v, gi, gr, nt, base;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R10 reset state
    peek(2'd0, v); chk("R10", "flags after reset", v, 8'h00);
    peek(2'd1, v); chk("R10", "wdog after reset", v, 8'h00);
    peek(2'd2, v); chk("R10", "ctrl after reset", v, 8'h00);
    chk("R10", "outputs after reset", {rst_req, irq}, 0);

    tick_auto_en = 1;
    // R1 field split and powers of four
    run_timeout("R1", 8'h0D, 12);
    run_timeout("R1", 8'h14, 5);
    run_timeout("R1", 8'h0B, 128);

    // R5 flag value, R7 control byte kept and one-shot
    cur_req = "R5";
    peek(2'd0, v); chk("R5", "flags after expiry", v, 8'h80);
    cur_req = "R7";
    peek(2'd1, v); chk("R7", "wdog kept", v, 8'h0B);
    base = irq_cnt;
    repeat (600) @(negedge clk);
    chk("R7", "no second expiry", irq_cnt, base);

    // R8 flag ignores bus writes
    cur_req = "R8";
    bus_wr(2'd0, 8'h00);
    peek(2'd0, v); chk("R8", "flag kept after write 0", v, 8'h80);

    // R3 write stores, clears flag, restarts
    cur_req = "R3";
    bus_wr(2'd1, 8'h0D);
    peek(2'd1, v); chk("R3", "stored byte", v, 8'h0D);
    peek(2'd0, v); chk("R3", "flag cleared by write", v, 8'h00);
    base = irq_cnt;
    for (int k = 0; k < 6; k++) begin
      repeat (24) @(negedge clk);
      bus_wr(2'd1, 8'h0D);
    end
    chk("R3", "rewrites keep it alive", irq_cnt, base);
    wait_fire(100, gi, gr, nt);
    chk("R3", "ticks after rewrite", nt, 12);

    // R4 flag read services
    cur_req = "R4";
    bus_wr(2'd1, 8'h14);
    base = irq_cnt;
    for (int k = 0; k < 10; k++) begin
      repeat (9) @(negedge clk);
      flags_rd(v);
    end
    chk("R4", "reads keep it alive", irq_cnt, base);
    wait_fire(60, gi, gr, nt);
    chk("R4", "ticks after last read", nt, 5);
    flags_rd(v); chk("R4", "read shows flag before clear", v, 8'h80);
    peek(2'd0, v); chk("R4", "flag cleared by read", v, 8'h00);
    bus_wr(2'd0, 8'hFF);
    peek(2'd0, v); chk("R8", "flag stays clear after write FF", v, 8'h00);

    // R2 zero multiplier disarms
    cur_req = "R2";
    base = irq_cnt + rst_cnt;
    bus_wr(2'd1, 8'h03);
    repeat (900) @(negedge clk);
    flags_rd(v);
    repeat (300) @(negedge clk);
    chk("R2", "no expiry with zero multiplier", irq_cnt + rst_cnt, base);
    peek(2'd0, v); chk("R2", "flag stays clear", v, 8'h00);

    // R9 reload wins over final tick
    cur_req = "R9";
    tick_auto_en = 0;
    bus_wr(2'd1, 8'h08);
    base = irq_cnt;
    man_tick();
    @(negedge clk); tick_man = 1; wr_en = 1; addr = 2'd1; wdata = 8'h08;
    @(negedge clk); tick_man = 0; wr_en = 0;
    repeat (5) @(negedge clk);
    chk("R9", "write on final tick wins", irq_cnt, base);
    repeat (10) @(negedge clk);
    chk("R9", "no expiry without ticks", irq_cnt, base);
    man_tick(); man_tick();
    repeat (3) @(negedge clk);
    chk("R9", "expiry after two ticks", irq_cnt, base + 1);
    bus_wr(2'd1, 8'h08);
    man_tick();
    @(negedge clk); tick_man = 1; rd_en = 1; addr = 2'd0;
    @(negedge clk); tick_man = 0; rd_en = 0;
    repeat (5) @(negedge clk);
    chk("R9", "flag read on final tick wins", irq_cnt, base + 1);

    // R6 steered expiry
    cur_req = "R6";
    tick_auto_en = 1;
    bus_wr(2'd2, 8'hFF);
    bus_wr(2'd1, 8'h84);
    wait_fire(30, gi, gr, nt);
    chk("R6", "rst_req fired", gr, 1);
    chk("R6", "irq not fired", gi, 0);
    chk("R6", "ticks to expiry", nt, 1);
    @(negedge clk);
    chk("R6", "rst_req one cycle", rst_req, 0);
    peek(2'd1, v); chk("R6", "wdog cleared", v, 8'h00);
    peek(2'd2, v); chk("R6", "neighbour bit 6 cleared", v, 8'hBF);
    flags_rd(v); chk("R5", "flag after steered expiry", v, 8'h80);
    base = rst_cnt + irq_cnt;
    repeat (300) @(negedge clk);
    chk("R6", "no timeout after steered reset", rst_cnt + irq_cnt, base);

    finish_run();
  end
endmodule